// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a small data cache that sits between a processor's single-word load/store port and a slower word-wide memory. Its lines are organised as sets of two ways; each line holds a tag, a valid flag, a dirty flag and a block of four words. A request presents a word address, and the set index picked from that address selects two candidate lines whose tags are compared at the same time. A read hit returns the word in the same cycle. A write hit updates the word only after the compare has confirmed the hit, marks the line dirty, and produces no memory traffic.

On a miss the controller picks the victim way from a one-bit first-in, first-out pointer kept for each set. If the victim holds modified data, its block is first copied out to memory. The missing block is then fetched. Each transfer moves four words, and each word takes a fixed number of cycles (five by default). A write miss loads the block and then completes as a write hit. The processor must hold its request stable until `cpu_ready` is high. The number of sets follows from the total capacity divided by the block size times the two ways.

Top module: `wb_cache`

## Requirements
- R1: After reset every line is invalid and every line is clean, so the first access to any address misses; with no request pending `cpu_ready` is high and `mem_rd`/`mem_wr` are low.
- R2: A word address is split from bit 0 upward into a 2-bit word offset, then the set index, then the tag. An access hits only when a way of the indexed set is valid and its stored tag equals the tag field. At most one way hits.
- R3: A read hit drives the addressed word on `cpu_rdata` with `cpu_ready` high in the same cycle the request is presented.
- R4: A write hit stores `cpu_wdata` into the addressed word at the next clock edge, with `cpu_ready` high in the presenting cycle. It marks the line dirty and causes no memory read or write.
- R5: A miss whose victim line is valid and dirty first writes the victim's four words to memory at `{victim tag, index, beat}` for beats 0, 1, 2, 3 in that order, and only then starts the refill.
- R6: A miss whose victim is clean or invalid goes straight to the refill, with no memory write. `cpu_ready` goes high 21 cycles after the request is first presented (1 + 4×5). With a dirty victim the delay is 41 cycles.
- R7: A write miss loads the whole block and then writes the word as a hit. The new value reaches memory only when that line is later evicted.
- R8: Each beat lasts BEAT_CYCLES cycles. `mem_rd` stays high through every cycle of the refill, and the memory word is captured in the last cycle of each beat. `mem_wr` pulses for one cycle, the last of each write-back beat.
- R9: Each set keeps a one-bit pointer that starts at way 0 and toggles on every refill into that set. The victim is always the way the pointer names, and hits never change the pointer.
- R10: `cpu_ready` stays low for the whole write-back and refill sequence.
- R11: Sets are independent: an access to one set neither hits on nor disturbs lines of another set holding the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request pending, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid while ready and request are high |
| cpu_ready | output | 1 | Request completes in this cycle (or idle) |
| mem_rd | output | 1 | Refill beat in progress |
| mem_wr | output | 1 | One-cycle write strobe at the end of a write-back beat |
| mem_addr | output | ADDR_W | Memory word address of the current beat |
| mem_wdata | output | DATA_W | Write-back word |
| mem_rdata | input | DATA_W | Memory word for the current refill beat |

## Verification
A hit completes in the cycle it is presented. A clean miss completes 21 cycles later and a dirty miss 41 cycles later, counting from the first cycle the request is shown. The bench drives each request just after a falling edge and re-samples `cpu_ready` just after every following falling edge. It counts those edges and compares the count with 0, 21 or 41, so each result is read in the middle of the cycle it is due. Memory traffic is sampled at falling edges as well. This gives the number of refill cycles (20 per block) and the number and order of write strobes without depending on the order of events at a rising edge.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } cstate_e;
endpackage

// File: rtl/beat_timer.sv
module beat_timer #(
    parameter int BEATS       = 4,
    parameter int BEAT_CYCLES = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    output logic [$clog2(BEATS)-1:0]   beat_idx,
    output logic                       beat_end,
    output logic                       xfer_end
);
    localparam int BW = $clog2(BEATS);
    localparam int CW = $clog2(BEAT_CYCLES);

    typedef struct packed {
        logic [BW-1:0] beat;
        logic [CW-1:0] cyc;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign beat_idx = tmr_q.beat;
    assign beat_end = run && (tmr_q.cyc == CW'(BEAT_CYCLES - 1));
    assign xfer_end = beat_end && (tmr_q.beat == BW'(BEATS - 1));

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d = '0;
        end else if (beat_end) begin
            tmr_d.cyc  = '0;
            tmr_d.beat = xfer_end ? '0 : tmr_q.beat + 1'b1;
        end else begin
            tmr_d.cyc = tmr_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !beat_end) |=> (beat_idx == $past(beat_idx)));

    // R8
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> (beat_idx == '0));
endmodule

// File: rtl/tag_match.sv
module tag_match #(
    parameter int TAG_W = 6,
    parameter int WAYS  = 2
) (
    input  logic [TAG_W-1:0]      lookup_tag,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]       way_valid,
    output logic [WAYS-1:0]       hit_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == lookup_tag);
    end
endmodule

// File: rtl/wb_cache.sv
module wb_cache
    import cache_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 10,
    parameter int BLK_WORDS   = 4,
    parameter int CACHE_WORDS = 32,
    parameter int BEAT_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WAYS  = 2;
    localparam int OFF_W = $clog2(BLK_WORDS);
    localparam int SETS  = CACHE_WORDS / (BLK_WORDS * WAYS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        cstate_e                    state;
        logic                       vict;
        logic [SETS-1:0][WAYS-1:0]  valid;
        logic [SETS-1:0][WAYS-1:0]  dirty;
        logic [SETS-1:0]            fifo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS][BLK_WORDS];

    logic [OFF_W-1:0] off;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    assign off = cpu_addr[OFF_W-1:0];
    assign idx = cpu_addr[OFF_W +: IDX_W];
    assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0]  hit_vec;
    logic             hit, hit_way;
    logic [OFF_W-1:0] beat;
    logic             beat_end, xfer_end;

    tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
        .lookup_tag (tag),
        .way_tags   ({tag_q[idx][1], tag_q[idx][0]}),
        .way_valid  (ctl_q.valid[idx]),
        .hit_vec    (hit_vec)
    );

    beat_timer #(.BEATS(BLK_WORDS), .BEAT_CYCLES(BEAT_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctl_q.state != ST_IDLE),
        .beat_idx (beat),
        .beat_end (beat_end),
        .xfer_end (xfer_end)
    );

    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];

    logic              data_we, tag_we, wr_way;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_val;

    always_comb begin
        ctl_d   = ctl_q;
        data_we = 1'b0;
        tag_we  = 1'b0;
        wr_way  = ctl_q.vict;
        wr_off  = beat;
        wr_val  = mem_rdata;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cpu_req && hit) begin
                    if (cpu_we) begin
                        data_we = 1'b1;
                        wr_way  = hit_way;
                        wr_off  = off;
                        wr_val  = cpu_wdata;
                        ctl_d.dirty[idx][hit_way] = 1'b1;
                    end
                end else if (cpu_req) begin
                    ctl_d.vict  = ctl_q.fifo[idx];
                    ctl_d.state = (ctl_q.valid[idx][ctl_q.fifo[idx]] &&
                                   ctl_q.dirty[idx][ctl_q.fifo[idx]]) ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                if (xfer_end) ctl_d.state = ST_FILL;
            end
            ST_FILL: begin
                data_we = beat_end;
                if (xfer_end) begin
                    tag_we                       = 1'b1;
                    ctl_d.valid[idx][ctl_q.vict] = 1'b1;
                    ctl_d.dirty[idx][ctl_q.vict] = 1'b0;
                    ctl_d.fifo[idx]              = ~ctl_q.fifo[idx];
                    ctl_d.state                  = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (data_we) data_q[idx][wr_way][wr_off] <= wr_val;
        if (tag_we)  tag_q[idx][ctl_q.vict]      <= tag;
    end

    assign cpu_rdata = data_q[idx][hit_way][off];
    assign cpu_ready = (ctl_q.state == ST_IDLE) && (!cpu_req || hit);
    assign mem_rd    = (ctl_q.state == ST_FILL);
    assign mem_wr    = (ctl_q.state == ST_WBACK) && beat_end;
    assign mem_wdata = data_q[idx][ctl_q.vict][beat];
    assign mem_addr  = (ctl_q.state == ST_WBACK) ? {tag_q[idx][ctl_q.vict], idx, beat}
                                                 : {tag, idx, beat};

    // R2
    one_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WBACK && xfer_end) |=> (ctl_q.state == ST_FILL));

    // R6
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_FILL && xfer_end) |=> (ctl_q.state == ST_IDLE));

    // R9
    fifo_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_FILL && xfer_end) |=> (ctl_q.fifo != $past(ctl_q.fifo)));

    // R9
    fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE) |=> (ctl_q.fifo == $past(ctl_q.fifo)));

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !cpu_ready);

    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

// File: tb/sim_wb_cache.sv
module sim_wb_cache;
    localparam int DW = 32;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata, mem_wdata, mem_rdata;
    logic          cpu_ready, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [AW-1:0] wlog [8];
    logic [DW-1:0] mem [1 << AW];

    always #5 clk = ~clk;

    wb_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];

    always @(negedge clk) begin
        if (mem_wr) begin
            mem[mem_addr] = mem_wdata;
            if (wr_cnt < 8) wlog[wr_cnt] = mem_addr;
            wr_cnt++;
        end
        if (mem_rd) rd_cnt++;
    end

    function automatic logic [AW-1:0] mk(input int t, input int s, input int o);
        return AW'((t << 4) | (s << 2) | o);
    endfunction

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return 32'hA500_0000 + DW'(a);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_cnt();
        wr_cnt = 0;
        rd_cnt = 0;
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        #1;
        while (!cpu_ready && cyc < 200) begin
            @(negedge clk); #1;
            cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk(cpu_ready == 1'b1, "R1 ready idle", DW'(cpu_ready), 1);
        chk(!mem_rd && !mem_wr, "R1 no traffic", DW'({mem_rd, mem_wr}), 0);
    endtask

    task automatic t_clean_miss();
        logic [DW-1:0] rd; int cyc;
        clr_cnt();
        access(1'b0, mk(1, 0, 2), '0, rd, cyc);
        chk(cyc == 21, "R6 R10 clean miss latency", DW'(cyc), 21);
        chk(rd == init_val(mk(1, 0, 2)), "R1 R2 miss data", rd, init_val(mk(1, 0, 2)));
        chk(wr_cnt == 0, "R6 no writeback", DW'(wr_cnt), 0);
        chk(rd_cnt == 20, "R8 refill cycles", DW'(rd_cnt), 20);
    endtask

    task automatic t_read_hit();
        logic [DW-1:0] rd; int cyc;
        clr_cnt();
        access(1'b0, mk(1, 0, 3), '0, rd, cyc);
        chk(cyc == 0, "R3 hit latency", DW'(cyc), 0);
        chk(rd == init_val(mk(1, 0, 3)), "R3 hit data", rd, init_val(mk(1, 0, 3)));
        chk(rd_cnt == 0, "R3 no refill", DW'(rd_cnt), 0);
    endtask

    task automatic t_write_hit();
        logic [DW-1:0] rd; int cyc;
        clr_cnt();
        access(1'b1, mk(1, 0, 1), 32'hDEAD_BEEF, rd, cyc);
        chk(cyc == 0, "R4 write hit latency", DW'(cyc), 0);
        access(1'b0, mk(1, 0, 1), '0, rd, cyc);
        chk(rd == 32'hDEAD_BEEF, "R4 write hit readback", rd, 32'hDEAD_BEEF);
        chk(wr_cnt == 0 && rd_cnt == 0, "R4 no memory traffic", DW'(wr_cnt + rd_cnt), 0);
        chk(mem[mk(1, 0, 1)] == init_val(mk(1, 0, 1)), "R4 memory untouched",
            mem[mk(1, 0, 1)], init_val(mk(1, 0, 1)));
    endtask

    task automatic t_fifo_evict();
        logic [DW-1:0] rd; int cyc;
        access(1'b0, mk(2, 0, 0), '0, rd, cyc);
        chk(cyc == 21, "R9 second way filled clean", DW'(cyc), 21);
        access(1'b0, mk(1, 0, 0), '0, rd, cyc);
        chk(cyc == 0, "R9 way0 still hits", DW'(cyc), 0);
        clr_cnt();
        access(1'b0, mk(3, 0, 0), '0, rd, cyc);
        chk(cyc == 41, "R5 R9 dirty oldest evicted", DW'(cyc), 41);
        chk(wr_cnt == 4, "R5 four write beats", DW'(wr_cnt), 4);
        chk(wlog[0] == mk(1, 0, 0) && wlog[3] == mk(1, 0, 3), "R5 beat order",
            DW'(wlog[0]), DW'(mk(1, 0, 0)));
        chk(mem[mk(1, 0, 1)] == 32'hDEAD_BEEF, "R5 dirty word copied out",
            mem[mk(1, 0, 1)], 32'hDEAD_BEEF);
        chk(rd == init_val(mk(3, 0, 0)), "R5 refill data", rd, init_val(mk(3, 0, 0)));
        access(1'b0, mk(2, 0, 0), '0, rd, cyc);
        chk(cyc == 0, "R9 not LRU: tag2 kept", DW'(cyc), 0);
        clr_cnt();
        access(1'b0, mk(1, 0, 0), '0, rd, cyc);
        chk(cyc == 21 && wr_cnt == 0, "R9 R6 clean way1 evicted", DW'(cyc), 21);
    endtask

    task automatic t_write_miss();
        logic [DW-1:0] rd; int cyc;
        access(1'b1, mk(5, 1, 2), 32'h1234_5678, rd, cyc);
        chk(cyc == 21, "R7 write miss allocates", DW'(cyc), 21);
        access(1'b0, mk(5, 1, 2), '0, rd, cyc);
        chk(cyc == 0 && rd == 32'h1234_5678, "R7 write merged", rd, 32'h1234_5678);
        access(1'b0, mk(5, 1, 3), '0, rd, cyc);
        chk(rd == init_val(mk(5, 1, 3)), "R7 rest of block loaded", rd, init_val(mk(5, 1, 3)));
        chk(mem[mk(5, 1, 2)] == init_val(mk(5, 1, 2)), "R7 memory not yet written",
            mem[mk(5, 1, 2)], init_val(mk(5, 1, 2)));
        access(1'b0, mk(6, 1, 0), '0, rd, cyc);
        access(1'b0, mk(7, 1, 0), '0, rd, cyc);
        chk(cyc == 41, "R7 dirty eviction latency", DW'(cyc), 41);
        chk(mem[mk(5, 1, 2)] == 32'h1234_5678, "R7 value reaches memory",
            mem[mk(5, 1, 2)], 32'h1234_5678);
    endtask

    task automatic t_set_indep();
        logic [DW-1:0] rd; int cyc;
        access(1'b0, mk(3, 2, 0), '0, rd, cyc);
        chk(cyc == 21, "R11 same tag other set misses", DW'(cyc), 21);
        access(1'b0, mk(3, 0, 0), '0, rd, cyc);
        chk(cyc == 0 && rd == init_val(mk(3, 0, 0)), "R11 set0 undisturbed",
            rd, init_val(mk(3, 0, 0)));
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = init_val(AW'(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clean_miss();
        t_read_hit();
        t_write_hit();
        t_fifo_evict();
        t_write_miss();
        t_set_indep();
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule